// File: doc/BRIEF.md
# Abortable DRAM Strobe Sequencer

This block drives the row strobe, column strobe, write enable, address-multiplexer select and data-buffer enable of a DRAM array that sits behind an asynchronous CPU bus. It is clocked at twice the CPU rate, so one clock step equals one CPU half-cycle. When the bus data strobe falls on an address that decodes into the array, the block drops the row strobe at once. This is a guess: an expansion card may still take the access by driving the strobe high again. The strobe is checked again on every row-only step. If it has gone high, the row strobe is released and no column strobe is issued, so memory is never written by an access that was taken away.

When the array is switched off, the block still pulses the row strobe on its own at a slow, parameter-set rate. Leaving the strobe idle for too long upsets the internal bias circuitry of older DRAM parts. The same row-only pulse is used after reset to issue a fixed number of warm-up cycles before the first real access is accepted.

Top module: `dram_cycle_seq`

## Requirements
- R1: While reset is held and in the first step after it, ras_n, cas_n and we_n are 1, and mux_col, buf_oe and cyc_done are 0.
- R2: After reset, exactly WARM_PULSES row-only pulses are issued. Each is KEEP_STEPS low followed by PRE_STEPS high, and each is preceded by PRE_STEPS high steps. No access is accepted before the last one finishes.
- R3: In the idle state with dram_en=1, addr_hit=1 and the strobe re-armed, a ds_n sampled low makes ras_n low in the very next step.
- R4: If ds_n is sampled high at any edge while only the row strobe is low, ras_n returns high in the next step. cas_n stays high for that whole access, and cyc_done is not raised.
- R5: When the strobe stays low, ras_n is low for ROW_STEPS steps before cas_n falls. Both are then low for COL_STEPS steps, and both are then high for PRE_STEPS steps. cas_n is never low while ras_n is high.
- R6: we_n is low on exactly the column steps of an access that began with rd_wr=0 (write). It stays high on reads (rd_wr=1).
- R7: mux_col is 1 from row step index ROW_HOLD (counting from 0) through the last column step. buf_oe is 1 only during the column steps of a read.
- R8: cyc_done is 1 for exactly one step, the first precharge step after a finished access. It is 0 at all other times.
- R9: After an access has started, no new access starts until ds_n has been sampled high.
- R10: While dram_en=0, row-only pulses of KEEP_STEPS low repeat, with falling edges KEEP_STEPS+PRE_STEPS+KA_INTERVAL steps apart. cas_n stays high, and ds_n has no effect.
- R11: A request that arrives during a keep-alive pulse waits. Its row strobe falls one step after the pulse's precharge ends.
- R12: A strobe with addr_hit=0 starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the CPU frequency |
| rst_n | input | 1 | Asynchronous reset, active low |
| ds_n | input | 1 | Bus data strobe, active low |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr_hit | input | 1 | Address falls inside the DRAM range |
| dram_en | input | 1 | 1 = array in use; 0 = keep-alive only |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | DRAM write enable, active low |
| mux_col | output | 1 | Address multiplexer: 1 selects column |
| buf_oe | output | 1 | Read data buffer output enable |
| cyc_done | output | 1 | One-step pulse when an access finishes |

## Verification
The bench builds the block with WARM_PULSES=3 and KA_INTERVAL=12, and keeps the step counts at 2 with ROW_HOLD=1. With these values the whole warm-up sequence and several keep-alive periods of 16 steps fit into a short run. Random strobe withdrawals can then land on every row step, and keep-alive pulses collide often with new requests. Directed cases cover abort on the first row step, a strobe held low through and past an access, and a request raised in the middle of a keep-alive pulse.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

   typedef enum logic [4:0] {
      ST_IDLE = 5'b00001,
      ST_ROW  = 5'b00010,
      ST_COL  = 5'b00100,
      ST_KEEP = 5'b01000,
      ST_PRE  = 5'b10000
   } seq_state_t;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dseq_phase_cnt.sv
module dseq_phase_cnt #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   output logic [W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (cnt != {W{1'b1}})
         cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/dseq_keepalive.sv
module dseq_keepalive #(
   parameter int ENABLE   = 1,
   parameter int INTERVAL = 3000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic fire
);

   localparam int KW = $clog2(INTERVAL + 1);

   generate
      if (ENABLE != 0) begin : g_timer
         logic [KW-1:0] gap_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               gap_q <= '0;
            else if (run)
               gap_q <= gap_q + 1'b1;
            else
               gap_q <= '0;
         end

         assign fire = run && (gap_q == KW'(INTERVAL - 1));
      end else begin : g_off
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ run;
         assign fire = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/dseq_ctrl.sv
module dseq_ctrl
   import dseq_pkg::*;
#(
   parameter int ROW_STEPS   = 2,
   parameter int COL_STEPS   = 2,
   parameter int PRE_STEPS   = 2,
   parameter int KEEP_STEPS  = 2,
   parameter int WARM_PULSES = 8,
   parameter int CW          = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ds_n,
   input  logic          rd_wr,
   input  logic          addr_hit,
   input  logic          dram_en,
   input  logic          ka_fire,
   input  logic [CW-1:0] cnt,
   output seq_state_t    state_q,
   output logic          phase_clr,
   output logic          ka_run,
   output logic          wr_q,
   output logic          done_q
);

   localparam int WW = max_of(1, $clog2(WARM_PULSES + 1));
   localparam logic [CW-1:0] ROW_LAST  = CW'(ROW_STEPS - 1);
   localparam logic [CW-1:0] COL_LAST  = CW'(COL_STEPS - 1);
   localparam logic [CW-1:0] PRE_LAST  = CW'(PRE_STEPS - 1);
   localparam logic [CW-1:0] KEEP_LAST = CW'(KEEP_STEPS - 1);

   seq_state_t    state_d;
   logic [WW-1:0] warm_q;
   logic          warm_dec;
   logic          armed_q;
   logic          accept;
   logic          done_d;

   assign accept = (state_q == ST_IDLE) && dram_en && addr_hit && !ds_n && armed_q;
   assign ka_run = (state_q == ST_IDLE) && !dram_en;

   always_comb begin
      state_d  = state_q;
      warm_dec = 1'b0;
      done_d   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (accept)
               state_d = ST_ROW;
            else if (ka_fire)
               state_d = ST_KEEP;
         end
         ST_ROW: begin
            if (ds_n)
               state_d = ST_PRE;
            else if (cnt == ROW_LAST)
               state_d = ST_COL;
         end
         ST_COL: begin
            if (cnt == COL_LAST) begin
               state_d = ST_PRE;
               done_d  = 1'b1;
            end
         end
         ST_KEEP: begin
            if (cnt == KEEP_LAST)
               state_d = ST_PRE;
         end
         ST_PRE: begin
            if (cnt == PRE_LAST) begin
               if (warm_q != '0) begin
                  state_d  = ST_KEEP;
                  warm_dec = 1'b1;
               end else begin
                  state_d = ST_IDLE;
               end
            end
         end
         default: state_d = ST_PRE;
      endcase
   end

   assign phase_clr = (state_d != state_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_PRE;
         warm_q  <= WW'(WARM_PULSES);
         armed_q <= 1'b1;
         wr_q    <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= done_d;
         if (warm_dec)
            warm_q <= warm_q - 1'b1;
         if (accept) begin
            armed_q <= 1'b0;
            wr_q    <= !rd_wr;
         end else if (ds_n) begin
            armed_q <= 1'b1;
         end
      end
   end

   // R9
   rearm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !armed_q) |=> (state_q != ST_ROW));

   // R2
   warm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> (warm_q == '0));

endmodule

// File: rtl/dseq_strobe_dec.sv
module dseq_strobe_dec
   import dseq_pkg::*;
#(
   parameter int ROW_HOLD = 1,
   parameter int CW       = 3
) (
   input  seq_state_t    state_q,
   input  logic [CW-1:0] cnt,
   input  logic          wr_q,
   input  logic          done_q,
   output logic          ras_n,
   output logic          cas_n,
   output logic          we_n,
   output logic          mux_col,
   output logic          buf_oe,
   output logic          cyc_done
);

   logic in_row, in_col, in_keep;

   assign in_row  = (state_q == ST_ROW);
   assign in_col  = (state_q == ST_COL);
   assign in_keep = (state_q == ST_KEEP);

   assign ras_n    = !(in_row || in_col || in_keep);
   assign cas_n    = !in_col;
   assign we_n     = !(in_col && wr_q);
   assign mux_col  = in_col || (in_row && (cnt >= CW'(ROW_HOLD)));
   assign buf_oe   = in_col && !wr_q;
   assign cyc_done = done_q;

endmodule

// File: rtl/dram_cycle_seq.sv
module dram_cycle_seq
   import dseq_pkg::*;
#(
   parameter int ROW_STEPS   = 2,
   parameter int COL_STEPS   = 2,
   parameter int PRE_STEPS   = 2,
   parameter int KEEP_STEPS  = 2,
   parameter int ROW_HOLD    = 1,
   parameter int WARM_PULSES = 8,
   parameter int KA_ENABLE   = 1,
   parameter int KA_INTERVAL = 3000,
   parameter int RAS_MAX_GAP = 32000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ds_n,
   input  logic rd_wr,
   input  logic addr_hit,
   input  logic dram_en,
   output logic ras_n,
   output logic cas_n,
   output logic we_n,
   output logic mux_col,
   output logic buf_oe,
   output logic cyc_done
);

   localparam int LONGEST = max_of(max_of(ROW_STEPS, COL_STEPS), max_of(PRE_STEPS, KEEP_STEPS));
   localparam int CW      = $clog2(LONGEST + 1) + 1;

   generate
      if (ROW_STEPS < 1 || COL_STEPS < 1 || PRE_STEPS < 1 || KEEP_STEPS < 1) begin : g_bad_steps
         $error("dram_cycle_seq: every step count must be at least 1");
      end
      if (ROW_HOLD < 1 || ROW_HOLD > ROW_STEPS) begin : g_bad_hold
         $error("dram_cycle_seq: ROW_HOLD must lie in 1..ROW_STEPS");
      end
      if (KA_INTERVAL < 1 || KA_INTERVAL + PRE_STEPS >= RAS_MAX_GAP) begin : g_bad_gap
         $error("dram_cycle_seq: keep-alive gap exceeds the row strobe limit");
      end
   endgenerate

   seq_state_t    state_q;
   logic [CW-1:0] cnt;
   logic          phase_clr;
   logic          ka_run;
   logic          ka_fire;
   logic          wr_q;
   logic          done_q;

   dseq_phase_cnt #(.W(CW)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (phase_clr),
      .cnt   (cnt)
   );

   dseq_keepalive #(.ENABLE(KA_ENABLE), .INTERVAL(KA_INTERVAL)) u_keep (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (ka_run),
      .fire  (ka_fire)
   );

   dseq_ctrl #(
      .ROW_STEPS   (ROW_STEPS),
      .COL_STEPS   (COL_STEPS),
      .PRE_STEPS   (PRE_STEPS),
      .KEEP_STEPS  (KEEP_STEPS),
      .WARM_PULSES (WARM_PULSES),
      .CW          (CW)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ds_n      (ds_n),
      .rd_wr     (rd_wr),
      .addr_hit  (addr_hit),
      .dram_en   (dram_en),
      .ka_fire   (ka_fire),
      .cnt       (cnt),
      .state_q   (state_q),
      .phase_clr (phase_clr),
      .ka_run    (ka_run),
      .wr_q      (wr_q),
      .done_q    (done_q)
   );

   dseq_strobe_dec #(.ROW_HOLD(ROW_HOLD), .CW(CW)) u_dec (
      .state_q  (state_q),
      .cnt      (cnt),
      .wr_q     (wr_q),
      .done_q   (done_q),
      .ras_n    (ras_n),
      .cas_n    (cas_n),
      .we_n     (we_n),
      .mux_col  (mux_col),
      .buf_oe   (buf_oe),
      .cyc_done (cyc_done)
   );

   // R4
   abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ROW && ds_n) |=> (ras_n && cas_n));

   // R5
   cas_under_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> !ras_n);

   // R5
   ras_leads_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n) |-> $past(!ras_n));

   // R6
   we_inside_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> !cas_n);

   // R7
   oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_oe |-> (!cas_n && we_n && mux_col));

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_done |=> !cyc_done);

   // R10
   keep_no_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_KEEP) |-> (cas_n && we_n && !buf_oe));

endmodule

// File: tb/dram_cycle_seq_test.sv
`timescale 1ns/1ps
module dram_cycle_seq_test;

   localparam int ROW_S = 2;
   localparam int COL_S = 2;
   localparam int PRE_S = 2;
   localparam int KEEP_S = 2;
   localparam int HOLD = 1;
   localparam int WARM = 3;
   localparam int KAI = 12;

   localparam int M_IDLE = 0, M_ROW = 1, M_COL = 2, M_KEEP = 3, M_PRE = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ds_n = 1'b0;
   logic rd_wr = 1'b1;
   logic addr_hit = 1'b1;
   logic dram_en = 1'b1;
   logic ras_n, cas_n, we_n, mux_col, buf_oe, cyc_done;

   int checks = 0;
   int errors = 0;
   bit chk_en = 1'b0;
   int wd = 0;

   always #4 clk = ~clk;

   dram_cycle_seq #(
      .ROW_STEPS(ROW_S), .COL_STEPS(COL_S), .PRE_STEPS(PRE_S), .KEEP_STEPS(KEEP_S),
      .ROW_HOLD(HOLD), .WARM_PULSES(WARM), .KA_ENABLE(1), .KA_INTERVAL(KAI),
      .RAS_MAX_GAP(1000)
   ) uut (
      .clk(clk), .rst_n(rst_n), .ds_n(ds_n), .rd_wr(rd_wr), .addr_hit(addr_hit),
      .dram_en(dram_en), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .mux_col(mux_col), .buf_oe(buf_oe), .cyc_done(cyc_done)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // reference model of the requirements
   int ms, mc, mka, mwarm;
   bit marm, mwr, mdone;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ms = M_PRE; mc = 0; mka = 0; mwarm = WARM; marm = 1; mwr = 0; mdone = 0;
      end else begin
         int ns;
         bit acc, kfire, ndone;
         ns = ms; ndone = 0;
         acc = (ms == M_IDLE) && dram_en && addr_hit && !ds_n && marm;
         kfire = (ms == M_IDLE) && !dram_en && (mka == KAI - 1);
         case (ms)
            M_IDLE: if (acc) ns = M_ROW; else if (kfire) ns = M_KEEP;
            M_ROW:  if (ds_n) ns = M_PRE; else if (mc == ROW_S - 1) ns = M_COL;
            M_COL:  if (mc == COL_S - 1) begin ns = M_PRE; ndone = 1; end
            M_KEEP: if (mc == KEEP_S - 1) ns = M_PRE;
            default: if (mc == PRE_S - 1) begin
                        if (mwarm > 0) begin ns = M_KEEP; mwarm--; end
                        else ns = M_IDLE;
                     end
         endcase
         mka = ((ms == M_IDLE) && !dram_en) ? mka + 1 : 0;
         if (acc) begin marm = 0; mwr = !rd_wr; end
         else if (ds_n) marm = 1;
         mc = (ns != ms) ? 0 : mc + 1;
         ms = ns;
         mdone = ndone;
      end
   end

   always @(negedge clk) begin
      if (chk_en) begin
         check("R5 ras_n", int'(ras_n), int'(!(ms == M_ROW || ms == M_COL || ms == M_KEEP)));
         check("R4 cas_n", int'(cas_n), int'(ms != M_COL));
         check("R6 we_n", int'(we_n), int'(!(ms == M_COL && mwr)));
         check("R7 mux_col", int'(mux_col), int'(ms == M_COL || (ms == M_ROW && mc >= HOLD)));
         check("R7 buf_oe", int'(buf_oe), int'(ms == M_COL && !mwr));
         check("R8 cyc_done", int'(cyc_done), int'(mdone));
      end
   end

   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic step();
      @(negedge clk);
   endtask

   task automatic idle_gap(input int n);
      ds_n = 1'b1;
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin
      int falls, gap, low_we, cas_seen, done_seen;
      bit prev, seen_high;
      void'($urandom(32'd2718));

      // R1: reset values
      step(); step();
      check("R1 ras_n", int'(ras_n), 1);
      check("R1 cas_n", int'(cas_n), 1);
      check("R1 we_n", int'(we_n), 1);
      check("R1 mux/oe/done", int'(mux_col) + int'(buf_oe) + int'(cyc_done), 0);
      rst_n = 1'b1;
      chk_en = 1'b1;
      step();
      check("R1 ras_n after release", int'(ras_n), 1);

      // R2: warm-up pulses before first access (strobe held low)
      falls = 0; prev = ras_n; cas_seen = 0;
      for (int i = 0; i < 200 && !cas_seen; i++) begin
         step();
         if (prev && !ras_n) falls++;
         prev = ras_n;
         if (!cas_n) cas_seen = 1;
      end
      check("R2 row pulses before first column", falls, WARM + 1);

      // R9: strobe kept low after access, no restart
      falls = 0; prev = ras_n;
      for (int i = 0; i < 14; i++) begin
         step();
         if (prev && !ras_n) falls++;
         prev = ras_n;
      end
      check("R9 no new cycle without strobe release", falls, 0);
      idle_gap(4);

      // R3: row strobe one step after strobe low
      rd_wr = 1'b1; ds_n = 1'b0;
      step();
      check("R3 ras_n low next step", int'(ras_n), 0);
      for (int i = 0; i < 6; i++) step();
      idle_gap(4);

      // R4: abort on first row step
      ds_n = 1'b0;
      step();
      ds_n = 1'b1;
      step();
      check("R4 ras_n released after abort", int'(ras_n), 1);
      cas_seen = 0; done_seen = 0;
      for (int i = 0; i < 8; i++) begin
         step();
         if (!cas_n) cas_seen++;
         if (cyc_done) done_seen++;
      end
      check("R4 no column strobe on abort", cas_seen, 0);
      check("R4 no done on abort", done_seen, 0);

      // R6: write cycle WE width
      rd_wr = 1'b0; ds_n = 1'b0; low_we = 0; done_seen = 0;
      for (int i = 0; i < 10; i++) begin
         step();
         if (!we_n) low_we++;
         if (cyc_done) done_seen++;
      end
      check("R6 we_n low steps on write", low_we, COL_S);
      check("R8 single done pulse", done_seen, 1);
      idle_gap(4);
      rd_wr = 1'b1;

      // R12: out-of-range strobe
      addr_hit = 1'b0; ds_n = 1'b0; falls = 0; prev = ras_n;
      for (int i = 0; i < 8; i++) begin
         step();
         if (prev && !ras_n) falls++;
         prev = ras_n;
      end
      check("R12 no cycle when address misses", falls, 0);
      addr_hit = 1'b1;
      idle_gap(3);

      // R10: keep-alive period
      dram_en = 1'b0;
      prev = ras_n; falls = 0; gap = 0; cas_seen = 0;
      for (int i = 0; i < 200 && falls < 3; i++) begin
         step();
         ds_n = 1'($urandom_range(0, 1));
         if (falls >= 1) gap++;
         if (!cas_n) cas_seen++;
         if (prev && !ras_n) begin
            falls++;
            if (falls == 3) check("R10 keep-alive spacing", gap, KEEP_S + PRE_S + KAI);
            gap = 0;
         end
         prev = ras_n;
      end
      check("R10 no column strobe while disabled", cas_seen, 0);

      // R11: request during keep-alive pulse
      ds_n = 1'b1;
      prev = ras_n;
      for (int i = 0; i < 100; i++) begin
         step();
         if (prev && !ras_n) break;
         prev = ras_n;
      end
      dram_en = 1'b1; ds_n = 1'b0; seen_high = 0; gap = 0;
      for (int i = 1; i < 20; i++) begin
         step();
         if (ras_n) seen_high = 1;
         else if (seen_high) begin gap = i; break; end
      end
      check("R11 held-off start delay", gap, KEEP_S + PRE_S + 1);
      step(); step();
      check("R11 column follows held-off start", int'(cas_n), 0);
      idle_gap(5);

      // random phase, checked against the model
      for (int i = 0; i < 4000; i++) begin
         step();
         if ($urandom_range(0, 3) == 0) ds_n = ~ds_n;
         if ($urandom_range(0, 9) == 0) rd_wr = 1'($urandom_range(0, 1));
         addr_hit = ($urandom_range(0, 9) != 0);
         if ($urandom_range(0, 199) == 0) dram_en = ~dram_en;
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule